// File: doc/BRIEF.md
# Byte-Wide SPI Controller

This block is an SPI peripheral that sits on a small CPU register bus. It works as a master or as a slave and exchanges one byte in both directions per transfer. Software sets it up through a control register and a status register. Software starts a transfer by writing the data register and collects the received byte by reading the same address. Bit order, clock polarity and clock phase are configurable. As master, the block generates SCK from the system clock at one of seven rates and frames every byte with an active-low select.

As a slave, the block takes SCK, select and MOSI from the pins through two-flop synchronizers. The system clock must therefore run several times faster than the incoming SCK. A completion flag can raise an interrupt request. A second flag records any attempt to write the data register while a byte is moving. That write is discarded.

Top module: `spi_ctrl`

## Requirements
- R1: Bus addresses are 0 for control, 1 for status and 2 for data; address 3 reads as zero. After reset, all three registers read zero, ss_no is high, irq_o is low and miso_oe_o is low.
- R2: In master mode with the enable bit set, a data write while idle loads the byte and drives ss_no low. The byte goes out on mosi_o while miso_i is shifted in, and the received byte is readable at address 2 after ss_no returns high.
- R3: Control bit 5 set shifts the least significant bit first; cleared, the most significant bit goes first. The same order applies to receive.
- R4: Control bit 3 is the SCK idle level (1 = idle high). Control bit 2 cleared samples data on the leading SCK edge and changes it on the trailing edge; set, it changes data on the leading edge and samples on the trailing edge.
- R5: The master SCK half period is 2^k system clocks, with k = b - 1 - d. Here b is 2, 4, 6 or 7 for control bits 1:0 = 0..3, and d is status bit 0. The master holds ss_no low for exactly 17 half periods per byte: 16 SCK edges plus one closing half period.
- R6: Status bit 7 is set when a byte completes. irq_o is high exactly while status bit 7 and control bit 7 are both 1.
- R7: A status read that sees bit 7 set, followed by any access to the data register, clears status bits 7 and 6.
- R8: A data write while a transfer is active sets status bit 6 and leaves the byte being shifted unchanged.
- R9: In slave mode (control bit 4 = 0), the block shifts on sck_i and mosi_i while ss_ni is low and returns its preloaded byte on miso_o. miso_oe_o is low whenever ss_ni is high.
- R10: In slave mode, ss_ni rising before the eighth bit aborts the byte without setting status bit 7 and restarts the bit count for the next byte.
- R11: With control bit 6 cleared, a data write starts nothing: ss_no stays high and status stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Transfer-complete interrupt request |
| sck_o | output | 1 | Master serial clock |
| ss_no | output | 1 | Master slave select, active low |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock |
| ss_ni | input | 1 | Slave select input, active low |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_oe_o | output | 1 | Slave output enable for miso_o |

## Verification
A stuck or miscounted edge counter shows at once as a wrong ss_no low window, which is measured in system clocks for five rate settings. A shift register that moves on the wrong edge or in the wrong direction corrupts the serial bit stream captured on MOSI at the sampling edges. It also corrupts the bytes read back from both ends within the same transfer. A wrong flag state shows on the status read and irq_o one access after the byte ends. A slave that keeps its bit count across an aborted byte returns a wrong byte on the very next transfer.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       ie;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // log2 of the SCK half period in system clocks
  function automatic logic [2:0] half_shift(input logic [1:0] rate, input logic dbl);
    logic [2:0] base;
    case (rate)
      2'd0:    base = 3'd2;
      2'd1:    base = 3'd4;
      2'd2:    base = 3'd6;
      default: base = 3'd7;
    endcase
    return base - 3'd1 - {2'b00, dbl};
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int MAX_SHIFT = 6,
  parameter int SW        = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [SW-1:0] shift_i,
  output logic          tick_o
);
  localparam int CW = MAX_SHIFT + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit  = CW'((32'd1 << shift_i) - 32'd1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          clr_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic          cpha_i,
  input  logic          lsb_i,
  input  logic          in_bit_i,
  output logic          out_bit_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   tx_q, rx_q;
  logic [CNTW-1:0] cnt_q;
  logic            sample, drive, room;

  assign room   = cnt_q < CNTW'(DW);
  assign sample = (cpha_i ? trail_i : lead_i) && room;
  // in phase 1 the first bit is already on the line before the first edge
  assign drive  = cpha_i ? (lead_i && cnt_q != '0) : trail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= sample && (cnt_q == CNTW'(DW - 1));
      if (load_i)     tx_q <= load_data_i;
      else if (drive) tx_q <= lsb_i ? (tx_q >> 1) : (tx_q << 1);
      if (sample)     rx_q <= lsb_i ? {in_bit_i, rx_q[DW-1:1]} : {rx_q[DW-2:0], in_bit_i};
      if (clr_i || load_i) cnt_q <= '0;
      else if (sample)     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_bit_o = lsb_i ? tx_q[0] : tx_q[DW-1];
  assign rx_o      = rx_q;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int SYNC_STG  = 2,
  parameter int MAX_SHIFT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             sck_o,
  output logic             ss_no,
  output logic             mosi_o,
  input  logic             miso_i,
  input  logic             sck_i,
  input  logic             ss_ni,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o
);
  localparam int EDGES = 2 * BUS_W;
  localparam int ECW   = $clog2(EDGES + 1);

  ctrl_t            ctrl_q;
  logic             dbl_q, flag_q, col_q, arm_q;
  logic [BUS_W-1:0] rx_buf_q;
  logic             busy_q, ss_q, sck_act_q;
  logic [ECW-1:0]   ecnt_q;
  logic             sck_d_q;

  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  logic master_en, slave_en, cfg_cpol, cfg_ie;
  logic sck_s, ss_s, mosi_s;
  logic s_act, xfer_act, start, load, collide;
  logic tick, m_lead, m_trail, m_end;
  logic s_edge, s_lead, s_trail;
  logic core_lead, core_trail, core_in, core_clr, core_out, core_done;
  logic [BUS_W-1:0] core_rx;
  logic flag_set, data_acc;

  assign wr_ctrl  = wr_i && addr_i == REG_CTRL;
  assign wr_stat  = wr_i && addr_i == REG_STAT;
  assign wr_data  = wr_i && addr_i == REG_DATA;
  assign rd_stat  = rd_i && addr_i == REG_STAT;
  assign rd_data  = rd_i && addr_i == REG_DATA;
  assign data_acc = wr_data || rd_data;

  assign master_en = ctrl_q.en && ctrl_q.master;
  assign slave_en  = ctrl_q.en && !ctrl_q.master;
  assign cfg_cpol  = ctrl_q.cpol;
  assign cfg_ie    = ctrl_q.ie;

  spi_sync #(.W(3), .STAGES(SYNC_STG), .RST(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   ({sck_s, ss_s, mosi_s})
  );

  assign s_act    = slave_en && !ss_s;
  assign xfer_act = busy_q || s_act;
  assign start    = wr_data && !xfer_act && master_en;
  assign load     = wr_data && !xfer_act;
  assign collide  = wr_data && xfer_act;

  spi_rate_gen #(.MAX_SHIFT(MAX_SHIFT), .SW(3)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .shift_i(half_shift(ctrl_q.rate, dbl_q)),
    .tick_o (tick)
  );

  // last tick closes a spare half period so select rises after SCK idles
  assign m_end   = tick && ecnt_q == ECW'(EDGES);
  assign m_lead  = tick && !m_end && !sck_act_q;
  assign m_trail = tick && !m_end && sck_act_q;

  assign s_edge  = sck_s ^ sck_d_q;
  assign s_lead  = s_act && s_edge && (sck_s ^ ctrl_q.cpol);
  assign s_trail = s_act && s_edge && !(sck_s ^ ctrl_q.cpol);

  assign core_lead  = ctrl_q.master ? m_lead  : s_lead;
  assign core_trail = ctrl_q.master ? m_trail : s_trail;
  assign core_in    = ctrl_q.master ? miso_i  : mosi_s;
  assign core_clr   = !ctrl_q.en || (!ctrl_q.master && ss_s);

  spi_shift_core #(.DW(BUS_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_data_i(wdata_i),
    .clr_i      (core_clr),
    .lead_i     (core_lead),
    .trail_i    (core_trail),
    .cpha_i     (ctrl_q.cpha),
    .lsb_i      (ctrl_q.lsb_first),
    .in_bit_i   (core_in),
    .out_bit_o  (core_out),
    .done_o     (core_done),
    .rx_o       (core_rx)
  );

  assign flag_set = master_en ? m_end : (slave_en && core_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      ss_q      <= 1'b1;
      sck_act_q <= 1'b0;
      ecnt_q    <= '0;
    end else if (!master_en) begin
      busy_q    <= 1'b0;
      ss_q      <= 1'b1;
      sck_act_q <= 1'b0;
      ecnt_q    <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      ss_q      <= 1'b0;
      sck_act_q <= 1'b0;
      ecnt_q    <= '0;
    end else if (m_end) begin
      busy_q <= 1'b0;
      ss_q   <= 1'b1;
    end else if (tick) begin
      sck_act_q <= !sck_act_q;
      ecnt_q    <= ecnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      dbl_q    <= 1'b0;
      flag_q   <= 1'b0;
      col_q    <= 1'b0;
      arm_q    <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i);
      if (wr_stat) dbl_q  <= wdata_i[0];
      if (rd_stat && flag_q) arm_q <= 1'b1;
      if (data_acc && arm_q) begin
        flag_q <= 1'b0;
        col_q  <= 1'b0;
        arm_q  <= 1'b0;
      end
      if (collide) col_q <= 1'b1;
      if (flag_set) begin
        flag_q   <= 1'b1;
        rx_buf_q <= core_rx;
      end
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = {flag_q, col_q, {(BUS_W-3){1'b0}}, dbl_q};
      REG_DATA: rdata_o = rx_buf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o     = cfg_ie && flag_q;
  assign sck_o     = master_en ? (cfg_cpol ^ sck_act_q) : cfg_cpol;
  assign ss_no     = ss_q;
  assign mosi_o    = master_en ? core_out : 1'b0;
  assign miso_o    = core_out;
  assign miso_oe_o = slave_en && !ss_ni;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int BUS_W     = 8,
  parameter int MAX_SHIFT = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic       master_en,
  input logic       cfg_cpol,
  input logic       xfer_act,
  input logic       flag_q,
  input logic       col_q,
  input logic       ss_no,
  input logic       sck_o,
  input logic       ss_ni,
  input logic       miso_oe_o
);
  localparam int LIMIT = (2 * BUS_W + 1) << MAX_SHIFT;
  localparam int LW    = $clog2(LIMIT + 2) + 1;

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_cnt <= '0;
    else if (ss_no) lo_cnt <= '0;
    else            lo_cnt <= lo_cnt + 1'b1;
  end

  a_r11_ss_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en |=> ss_no);

  a_r4_sck_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_en && ss_no && $past(ss_no)) |-> sck_o == cfg_cpol);

  a_r9_miso_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_ni |-> !miso_oe_o);

  a_r8_col_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && xfer_act) |=> col_q);

  a_r6_flag_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_q) && master_en) |-> ss_no);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past((wr_i || rd_i) && addr_i == 2'd2));

  a_r5_ss_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cnt <= LW'(LIMIT));
endmodule

bind spi_ctrl spi_ctrl_chk #(.BUS_W(BUS_W), .MAX_SHIFT(MAX_SHIFT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .master_en(master_en),
  .cfg_cpol (cfg_cpol),
  .xfer_act (xfer_act),
  .flag_q   (flag_q),
  .col_q    (col_q),
  .ss_no    (ss_no),
  .sck_o    (sck_o),
  .ss_ni    (ss_ni),
  .miso_oe_o(miso_oe_o)
);

// File: tb/sim_spi_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] addr0 = '0, addr1 = '0;
  logic       wr0 = 0, rd0 = 0, wr1 = 0, rd1 = 0;
  logic [7:0] wd0 = '0, wd1 = '0;
  logic [7:0] rdata0, rdata1;
  logic       irq0, irq1;
  logic       sck_m, ss_m, mosi_m;
  logic       u0_miso, u0_oe, u1_sck, u1_ss, u1_mosi, u1_miso, u1_oe;
  logic       ss_kill = 1'b0;
  logic       miso_line;

  assign miso_line = u1_oe ? u1_miso : 1'b0;

  spi_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr0), .wr_i(wr0), .rd_i(rd0),
    .wdata_i(wd0), .rdata_o(rdata0), .irq_o(irq0),
    .sck_o(sck_m), .ss_no(ss_m), .mosi_o(mosi_m), .miso_i(miso_line),
    .sck_i(1'b0), .ss_ni(1'b1), .mosi_i(1'b0),
    .miso_o(u0_miso), .miso_oe_o(u0_oe)
  );

  spi_ctrl u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr1), .wr_i(wr1), .rd_i(rd1),
    .wdata_i(wd1), .rdata_o(rdata1), .irq_o(irq1),
    .sck_o(u1_sck), .ss_no(u1_ss), .mosi_o(u1_mosi), .miso_i(1'b0),
    .sck_i(sck_m), .ss_ni(ss_m | ss_kill), .mosi_i(mosi_m),
    .miso_o(u1_miso), .miso_oe_o(u1_oe)
  );

  int nchk = 0, nfail = 0;
  logic mon_on = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic [7:0] cap = '0;
  int capn = 0;

  // bench-side capture of MOSI at the sampling edges
  always @(sck_m) begin
    if (mon_on && ss_m === 1'b0) begin
      if ((sck_m !== mon_cpol) ^ mon_cpha) begin
        cap  = {cap[6:0], mosi_m};
        capn = capn + 1;
      end
    end
  end

  // {lsb, cpol, cpha, master byte, slave byte}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b0, 1'b1, 8'hC3, 8'h5A},
    {1'b0, 1'b1, 1'b0, 8'h0F, 8'hF0},
    {1'b0, 1'b1, 1'b1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'hB4, 8'h2D},
    {1'b1, 1'b0, 1'b1, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b0, 8'hE7, 8'h18},
    {1'b1, 1'b1, 1'b1, 8'h6C, 8'h93}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (w == 0) begin addr0 = a; wd0 = d; wr0 = 1'b1; end
    else        begin addr1 = a; wd1 = d; wr1 = 1'b1; end
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input int w, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (w == 0) begin addr0 = a; rd0 = 1'b1; end
    else        begin addr1 = a; rd1 = 1'b1; end
    #1 d = (w == 0) ? rdata0 : rdata1;
    @(negedge clk);
    rd0 = 1'b0; rd1 = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (ss_m !== 1'b1 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic measure(input logic [1:0] rate, input logic dbl, input int exp);
    int n = 0;
    logic [7:0] d;
    wr(0, 2'd0, {6'b010100, rate});
    wr(0, 2'd1, {7'b0, dbl});
    wr(0, 2'd2, 8'h55);
    while (ss_m === 1'b0 && n < 3000) begin
      n++;
      @(negedge clk);
    end
    chk("R5 ss low window", n, exp);
    repeat (3) @(negedge clk);
    rd(0, 2'd1, d);
    chk("R6 flag with irq disabled", {d[7], irq0}, 2'b10);
    rd(0, 2'd2, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 2'd0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(0, 2'd1, d); chk("R1 status reset", d, 8'h00);
    rd(0, 2'd2, d); chk("R1 data reset", d, 8'h00);
    rd(0, 2'd3, d); chk("R1 unused address", d, 8'h00);
    chk("R1 select/irq/oe reset", {ss_m, irq0, u1_oe}, 3'b100);

    // R2 R3 R4 R6 R7 R9 vector walk
    for (int v = 0; v < 8; v++) begin
      logic lsb, cpol, cpha;
      logic [7:0] mb, sb;
      {lsb, cpol, cpha, mb, sb} = VEC[v];
      wr(1, 2'd0, {2'b01, lsb, 1'b0, cpol, cpha, 2'b00});
      wr(1, 2'd2, sb);
      wr(0, 2'd0, {2'b11, lsb, 1'b1, cpol, cpha, 2'b01});
      wr(0, 2'd1, 8'h00);
      mon_cpol = cpol; mon_cpha = cpha; cap = '0; capn = 0; mon_on = 1'b1;
      wr(0, 2'd2, mb);
      wait_done();
      mon_on = 1'b0;
      chk("R3 R4 serial order on mosi", cap, lsb ? rev8(mb) : mb);
      chk("R4 sampling edge count", capn, 8);
      chk("R4 sck idle level", sck_m, cpol);
      chk("R6 irq after byte", irq0, 1'b1);
      rd(0, 2'd1, d); chk("R6 flag set", d, 8'h80);
      rd(0, 2'd2, d); chk("R2 master received byte", d, sb);
      rd(0, 2'd1, d); chk("R7 flags cleared", d, 8'h00);
      chk("R7 irq cleared", irq0, 1'b0);
      rd(1, 2'd1, d); chk("R9 slave flag set", d, 8'h80);
      rd(1, 2'd2, d); chk("R9 slave received byte", d, mb);
    end

    // R5 rates, slave off
    wr(1, 2'd0, 8'h00);
    measure(2'd0, 1'b1, 17);
    measure(2'd0, 1'b0, 34);
    measure(2'd1, 1'b1, 68);
    measure(2'd2, 1'b0, 544);
    measure(2'd3, 1'b0, 1088);

    // R8 collision
    wr(1, 2'd0, 8'h40);
    wr(1, 2'd2, 8'h3C);
    wr(0, 2'd0, 8'h51);
    wr(0, 2'd1, 8'h00);
    wr(0, 2'd2, 8'hA5);
    repeat (40) @(negedge clk);
    wr(0, 2'd2, 8'hFF);
    wait_done();
    rd(0, 2'd1, d); chk("R8 collision flag", d, 8'hC0);
    rd(0, 2'd2, d); chk("R8 master rx intact", d, 8'h3C);
    rd(0, 2'd1, d); chk("R7 both flags cleared", d, 8'h00);
    rd(1, 2'd1, d);
    rd(1, 2'd2, d); chk("R8 shifted byte unchanged", d, 8'hA5);

    // R10 abort and R9 tri-state
    wr(1, 2'd2, 8'h81);
    wr(0, 2'd2, 8'h5A);
    repeat (60) @(negedge clk);
    ss_kill = 1'b1;
    #1 chk("R9 miso released on select high", u1_oe, 1'b0);
    wait_done();
    ss_kill = 1'b0;
    repeat (5) @(negedge clk);
    rd(1, 2'd1, d); chk("R10 no flag after abort", d, 8'h00);
    rd(0, 2'd1, d);
    rd(0, 2'd2, d);
    wr(1, 2'd2, 8'h66);
    wr(0, 2'd2, 8'h99);
    wait_done();
    rd(1, 2'd1, d); chk("R10 flag after clean byte", d, 8'h80);
    rd(1, 2'd2, d); chk("R10 slave byte after abort", d, 8'h99);
    rd(0, 2'd1, d);
    rd(0, 2'd2, d); chk("R10 master byte after abort", d, 8'h66);

    // R11 disabled master
    wr(0, 2'd0, 8'h11);
    wr(0, 2'd2, 8'h12);
    begin
      int lows = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (ss_m !== 1'b1) lows++;
      end
      chk("R11 select stays high", lows, 0);
    end
    rd(0, 2'd1, d); chk("R11 status stays zero", d, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule